// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block drives a three-wire serial EEPROM. The host presents a command code, an address, write data and a bit count, and pulses a start strobe. The block then raises an active-high chip select and waits out a setup time. It clocks a frame to the device, most significant bit first. Each bit has its own data-setup time and fixed clock high and low times. On a read it skips the device's leading zero and shifts in the requested number of data bits.

Commands that change the array (program, erase, and their all-location forms) end with a ready poll. The chip select is dropped briefly and raised again. The data-in line is then sampled at a fixed spacing until it reads high or a bounded number of samples has passed. The host sees `busy` while the transaction runs and a one-cycle `done`. The `ok` flag, which is valid from `done` on, tells success from a poll timeout. All timing is set in system clock cycles through parameters.

Top module: `mw_eeprom_master`

## Requirements
- R1: Each frame starts with a 1, then a 2-bit opcode, then ADDR_W address bits, all sent MSB first. The opcode is 10 for READ, 01 for WRITE, 11 for ERASE and 00 for the extended group. The `cmd` codes are 0 READ, 1 WRITE, 2 ERASE, 3 EWDS, 4 WRAL, 5 ERAL and 6 EWEN.
- R2: Extended commands send opcode 00. The top two address-field bits select the command: 00 EWDS, 01 WRAL, 10 ERAL, 11 EWEN. The rest of the address field is sent as 0 and `addr` is ignored.
- R3: WRITE and WRAL append the `dlen` low bits of `wdata` after the address, MSB first. No other command sends data bits.
- R4: Each frame bit is on `mw_do` for T_SU cycles before its rising clock edge and stays unchanged while `mw_sclk` is high. Every clock high phase lasts exactly T_HIGH cycles, and each low phase lasts at least T_LOW cycles.
- R5: `mw_cs` rises exactly T_CSS+T_SU cycles before the first rising `mw_sclk`. After the last phase, `mw_cs` stays low for T_CSH cycles, and `done` is given in the last of those cycles.
- R6: READ gives dlen+1 clock pulses after the address, with `mw_do` held at 0. The first pulse's data is discarded. The next `dlen` bits are sampled at the end of each high phase, MSB first, into the low bits of `rd_data`.
- R7: WRITE, ERASE, WRAL and ERAL drop `mw_cs` for T_CSH cycles after the last bit, then raise it again. `mw_di` is then sampled every POLL_GAP cycles with no clock pulses. The first high sample ends the poll with `ok`=1.
- R8: If POLL_MAX samples in a row read low, the poll ends with `ok`=0. In that case `mw_cs` stays high for exactly POLL_MAX*POLL_GAP cycles.
- R9: READ, EWEN and EWDS finish without a poll and report `ok`=1.
- R10: `busy` is high from the cycle after an accepted start until `done`, which lasts one cycle. A start while busy is ignored.
- R11: While idle, `mw_cs`, `mw_sclk` and `mw_do` are low. `mw_sclk` is never high while `mw_cs` is low.
- R12: A start with `cmd`=7 is not accepted: `busy` stays low and no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, taken when idle |
| cmd | input | 3 | Command code (R1) |
| addr | input | ADDR_W | Device address |
| wdata | input | DATA_W | Data for WRITE and WRAL |
| dlen | input | LEN_W | Data bit count for write or read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | 1 = success, 0 = poll timeout |
| rd_data | output | DATA_W | Read result, right-aligned |
| mw_cs | output | 1 | Chip select, active high |
| mw_sclk | output | 1 | Serial clock |
| mw_do | output | 1 | Serial data to device |
| mw_di | input | 1 | Serial data / ready from device |

## Verification
The bench models the device's read shifter: it puts out a dummy zero and then data on falling clock edges. A design that captures the dummy bit, or one that misses the extra pulse, returns a read word shifted by one position. Ready is raised at chosen cycles inside the poll window to check the exact count of samples. A design whose sampling spacing or give-up count is off shows the wrong chip-select high time, or reports timeout or success wrongly. Short write lengths, the four extended encodings, a start strobe during a busy transaction and the unused command code all target the corner cases of frame building. A design with any of these wrong sends a frame with the wrong bit count, or starts a second transaction.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_EWDS  = 3'd3,
    CMD_WRAL  = 3'd4,
    CMD_ERAL  = 3'd5,
    CMD_EWEN  = 3'd6,
    CMD_NONE  = 3'd7
  } mw_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CS_SETUP,
    ST_BIT_SETUP,
    ST_BIT_HIGH,
    ST_BIT_LOW,
    ST_RD_HIGH,
    ST_RD_LOW,
    ST_POLL_DROP,
    ST_POLL_WAIT,
    ST_CS_HOLD
  } mw_state_e;

  // Two-bit opcode sent right after the start bit.
  function automatic logic [1:0] op_bits(mw_cmd_e c);
    case (c)
      CMD_READ:  return 2'b10;
      CMD_WRITE: return 2'b01;
      CMD_ERASE: return 2'b11;
      default:   return 2'b00;
    endcase
  endfunction

  function automatic logic is_ext(mw_cmd_e c);
    return (c == CMD_EWDS) || (c == CMD_WRAL) || (c == CMD_ERAL) || (c == CMD_EWEN);
  endfunction

  // Selector carried in the top of the address field for the extended group.
  function automatic logic [1:0] ext_bits(mw_cmd_e c);
    case (c)
      CMD_WRAL: return 2'b01;
      CMD_ERAL: return 2'b10;
      CMD_EWEN: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  function automatic logic has_wdata(mw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRAL);
  endfunction

  function automatic logic has_rdata(mw_cmd_e c);
    return c == CMD_READ;
  endfunction

  function automatic logic needs_poll(mw_cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_WRAL) || (c == CMD_ERAL);
  endfunction

  function automatic logic cmd_legal(mw_cmd_e c);
    return c != CMD_NONE;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  // A phase loaded with N-1 lasts N cycles; expiry marks its last cycle.
  assign expired = (cnt == '0);

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
  import mw_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 5,
  parameter int FRAME_W = 3 + ADDR_W + DATA_W,
  parameter int CNT_W   = 5
) (
  input  mw_cmd_e              cmd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [LEN_W-1:0]     dlen,
  output logic [FRAME_W-1:0]   frame,
  output logic [CNT_W-1:0]     nbits
);

  localparam int HDR_W = 3 + ADDR_W;

  // Put the data bits at the left of their field so they follow the address.
  function automatic logic [DATA_W-1:0] left_align(logic [DATA_W-1:0] d, logic [LEN_W-1:0] n);
    return d << (DATA_W - int'(n));
  endfunction

  logic [ADDR_W-1:0] afield;
  logic [DATA_W-1:0] dfield;

  always_comb begin
    if (is_ext(cmd)) afield = {ext_bits(cmd), {(ADDR_W-2){1'b0}}};
    else             afield = addr;
    dfield = has_wdata(cmd) ? left_align(wdata, dlen) : '0;
    frame  = {1'b1, op_bits(cmd), afield, dfield};
    nbits  = has_wdata(cmd) ? CNT_W'(HDR_W + int'(dlen)) : CNT_W'(HDR_W);
  end

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data <= '0;
    else if (clr)      data <= '0;
    else if (shift_en) data <= {data[DATA_W-2:0], bit_in};
  end

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int LEN_W    = $clog2(DATA_W + 1),
  parameter int T_CSS    = 125,
  parameter int T_SU     = 125,
  parameter int T_HIGH   = 125,
  parameter int T_LOW    = 125,
  parameter int T_CSH    = 125,
  parameter int POLL_GAP = 125,
  parameter int POLL_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LEN_W-1:0]  dlen,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [DATA_W-1:0] rd_data,
  output logic              mw_cs,
  output logic              mw_sclk,
  output logic              mw_do,
  input  logic              mw_di
);

  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int RDC_W   = $clog2(DATA_W + 2);
  localparam int PCNT_W  = $clog2(POLL_MAX + 1);
  localparam int TMAX    = max2(max2(max2(T_CSS, T_SU), max2(T_HIGH, T_LOW)),
                                max2(T_CSH, POLL_GAP));
  localparam int TW      = $clog2(TMAX + 1);

  // Length in cycles of the phase that a state stands for.
  function automatic int phase_cycles(mw_state_e s);
    case (s)
      ST_CS_SETUP:  return T_CSS;
      ST_BIT_SETUP: return T_SU;
      ST_BIT_HIGH:  return T_HIGH;
      ST_BIT_LOW:   return T_LOW;
      ST_RD_HIGH:   return T_HIGH;
      ST_RD_LOW:    return T_LOW;
      ST_POLL_DROP: return T_CSH;
      ST_POLL_WAIT: return POLL_GAP;
      ST_CS_HOLD:   return T_CSH;
      default:      return 1;
    endcase
  endfunction

  mw_state_e          st, st_n;
  mw_cmd_e            cmd_in, cmd_q;
  logic [FRAME_W-1:0] fb_frame, frame_q;
  logic [CNT_W-1:0]   fb_nbits, bits_left_q;
  logic [LEN_W-1:0]   dlen_c, dlen_q;
  logic [RDC_W-1:0]   rd_left_q;
  logic               dummy_q;
  logic [PCNT_W-1:0]  poll_n_q;
  logic               ok_q;
  logic               tmr_expired;

  // Named events, used by the datapath and the assertions.
  logic accept, phase_end, step;
  logic bit_sent, last_bit, last_rd, rd_enter;
  logic rd_sample, poll_sample, poll_ready, poll_give_up;

  assign cmd_in    = mw_cmd_e'(cmd);
  assign dlen_c    = (int'(dlen) > DATA_W) ? LEN_W'(DATA_W) : dlen;
  assign accept    = start && (st == ST_IDLE) && cmd_legal(cmd_in);
  assign phase_end = (st != ST_IDLE) && tmr_expired;
  assign step      = accept || phase_end;

  assign last_bit     = (bits_left_q == CNT_W'(1));
  assign last_rd      = (rd_left_q == RDC_W'(1));
  assign bit_sent     = (st == ST_BIT_LOW) && phase_end;
  assign rd_enter     = bit_sent && last_bit && has_rdata(cmd_q);
  assign rd_sample    = (st == ST_RD_HIGH) && phase_end && !dummy_q;
  assign poll_sample  = (st == ST_POLL_WAIT) && phase_end;
  assign poll_ready   = poll_sample && mw_di;
  assign poll_give_up = poll_sample && !mw_di && (poll_n_q == PCNT_W'(POLL_MAX - 1));

  mw_frame_build #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_frame (
    .cmd  (cmd_in),
    .addr (addr),
    .wdata(wdata),
    .dlen (dlen_c),
    .frame(fb_frame),
    .nbits(fb_nbits)
  );

  mw_phase_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (step),
    .load_val(TW'(phase_cycles(st_n) - 1)),
    .expired (tmr_expired)
  );

  mw_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .shift_en(rd_sample),
    .bit_in  (mw_di),
    .data    (rd_data)
  );

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:      if (accept)    st_n = ST_CS_SETUP;
      ST_CS_SETUP:  if (phase_end) st_n = ST_BIT_SETUP;
      ST_BIT_SETUP: if (phase_end) st_n = ST_BIT_HIGH;
      ST_BIT_HIGH:  if (phase_end) st_n = ST_BIT_LOW;
      ST_BIT_LOW: begin
        if (phase_end) begin
          if (!last_bit)                 st_n = ST_BIT_SETUP;
          else if (has_rdata(cmd_q))     st_n = ST_RD_HIGH;
          else if (needs_poll(cmd_q))    st_n = ST_POLL_DROP;
          else                           st_n = ST_CS_HOLD;
        end
      end
      ST_RD_HIGH:   if (phase_end) st_n = ST_RD_LOW;
      ST_RD_LOW:    if (phase_end) st_n = last_rd ? ST_CS_HOLD : ST_RD_HIGH;
      ST_POLL_DROP: if (phase_end) st_n = ST_POLL_WAIT;
      ST_POLL_WAIT: if (poll_ready || poll_give_up) st_n = ST_CS_HOLD;
      ST_CS_HOLD:   if (phase_end) st_n = ST_IDLE;
      default:      st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cmd_q       <= CMD_READ;
      frame_q     <= '0;
      bits_left_q <= '0;
      dlen_q      <= '0;
      rd_left_q   <= '0;
      dummy_q     <= 1'b0;
      poll_n_q    <= '0;
      ok_q        <= 1'b0;
    end else begin
      st <= st_n;
      if (accept) begin
        cmd_q       <= cmd_in;
        frame_q     <= fb_frame;
        bits_left_q <= fb_nbits;
        dlen_q      <= dlen_c;
        poll_n_q    <= '0;
      end
      if (bit_sent && !last_bit) begin
        frame_q     <= frame_q << 1;
        bits_left_q <= bits_left_q - 1'b1;
      end
      if (rd_enter) begin
        rd_left_q <= RDC_W'(dlen_q) + 1'b1;
        dummy_q   <= 1'b1;
      end
      if ((st == ST_RD_HIGH) && phase_end) dummy_q <= 1'b0;
      if ((st == ST_RD_LOW) && phase_end)  rd_left_q <= rd_left_q - 1'b1;
      if (poll_sample && !poll_ready && !poll_give_up) poll_n_q <= poll_n_q + 1'b1;
      if (accept)
        ok_q <= 1'b0;
      else if (poll_sample)
        ok_q <= mw_di;
      else if (phase_end && (st_n == ST_CS_HOLD) && (st != ST_CS_HOLD))
        ok_q <= 1'b1;
    end
  end

  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_CS_HOLD) && phase_end;
  assign ok      = ok_q;
  assign mw_cs   = (st == ST_CS_SETUP) || (st == ST_BIT_SETUP) || (st == ST_BIT_HIGH) ||
                   (st == ST_BIT_LOW)  || (st == ST_RD_HIGH)   || (st == ST_RD_LOW)   ||
                   (st == ST_POLL_WAIT);
  assign mw_sclk = (st == ST_BIT_HIGH) || (st == ST_RD_HIGH);
  assign mw_do   = ((st == ST_BIT_SETUP) || (st == ST_BIT_HIGH) || (st == ST_BIT_LOW)) &&
                   frame_q[FRAME_W-1];

  // ---------------- assertions ----------------
  assert_sclk_needs_cs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sclk |-> mw_cs);

  assert_do_held_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sclk && $past(mw_sclk)) |-> $stable(mw_do));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_start_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cmd_q == $past(cmd_q)));

  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_n_q < PCNT_W'(POLL_MAX));

  assert_capture_in_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |-> (mw_sclk && mw_cs));

  assert_ok_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ok);

endmodule

// File: tb/sim_mw_eeprom_master.sv
`timescale 1ns/1ps
module sim_mw_eeprom_master;

  localparam int ADDR_W = 7, DATA_W = 16, LEN_W = 5;
  localparam int T_CSS = 3, T_SU = 2, T_HIGH = 3, T_LOW = 2, T_CSH = 4;
  localparam int POLL_GAP = 5, POLL_MAX = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [2:0] cmd = 0;
  logic [ADDR_W-1:0] addr = 0;
  logic [DATA_W-1:0] wdata = 0;
  logic [LEN_W-1:0] dlen = 0;
  logic busy, done, ok, cs, sclk, dout, di;
  logic [DATA_W-1:0] rd_data;

  always #4 clk = ~clk;  // 125 MHz

  mw_eeprom_master #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .T_CSS(T_CSS), .T_SU(T_SU), .T_HIGH(T_HIGH), .T_LOW(T_LOW), .T_CSH(T_CSH),
    .POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .wdata(wdata),
    .dlen(dlen), .busy(busy), .done(done), .ok(ok), .rd_data(rd_data),
    .mw_cs(cs), .mw_sclk(sclk), .mw_do(dout), .mw_di(di)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit wd = 0;

  // task-driven controls for the monitor / device model
  bit mon_clr = 0, rd_mode = 0;
  logic [DATA_W-1:0] rd_vec = 0;
  int rd_len = 0, rdy_after = -1, exp_tx = 0;

  // monitor state
  logic [63:0] obs = 0;
  int obs_n = 0, cs_sess = 0, cs_lo = 0, gap_lo = 0, pre_cyc = 0, setup_seen = 0;
  int do_age = 0, hi_cnt = 0, lo_cnt = 0, t_err = 0, falls = 0, poll_hi = 0, lo_at_done = 0;
  logic p_cs = 0, p_sclk = 0, p_do = 0, di_rd = 0, di_pl = 0;

  assign di = rd_mode ? di_rd : di_pl;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) wd = 1;
  end

  always @(negedge clk) begin
    if (mon_clr) begin
      obs = 0; obs_n = 0; cs_sess = 0; cs_lo = 0; gap_lo = 0; pre_cyc = 0; setup_seen = 0;
      do_age = 0; hi_cnt = 0; lo_cnt = 0; t_err = 0; falls = 0; poll_hi = 0; lo_at_done = 0;
      di_rd = 0; di_pl = 0; p_cs = cs; p_sclk = sclk; p_do = dout;
    end else begin
      if (cs && !p_cs) begin
        cs_sess++;
        if (cs_sess == 2) gap_lo = cs_lo;
      end
      cs_lo = cs ? 0 : cs_lo + 1;
      if (done) lo_at_done = cs_lo;
      if (cs && cs_sess == 1 && obs_n == 0 && !sclk) pre_cyc++;
      do_age = (dout != p_do) ? 1 : do_age + 1;
      if (sclk && !p_sclk) begin
        if (obs_n == 0) setup_seen = pre_cyc;
        if (obs_n > 0 && lo_cnt < T_LOW) t_err++;
        if (obs_n < exp_tx && do_age < T_SU + 1) t_err++;
        if (cs_sess == 1) begin obs = {obs[62:0], dout}; obs_n++; end
      end
      if (sclk) begin
        hi_cnt = p_sclk ? hi_cnt + 1 : 1;
        if (p_sclk && dout != p_do) t_err++;
        lo_cnt = 0;
      end else begin
        lo_cnt++;
      end
      if (!sclk && p_sclk) begin
        if (hi_cnt != T_HIGH) t_err++;
        falls++;
        if (falls == 3 + ADDR_W) di_rd = 0;
        else if (falls > 3 + ADDR_W) begin
          int idx;
          idx = falls - (4 + ADDR_W);
          di_rd = (idx < rd_len) ? rd_vec[rd_len - 1 - idx] : 1'b0;
        end
      end
      if (cs && cs_sess == 2) begin
        poll_hi++;
        if (rdy_after >= 0 && poll_hi >= rdy_after) di_pl = 1;
      end
      p_cs = cs; p_sclk = sclk; p_do = dout;
    end
  end

  task automatic chk(input bit c, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!c) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Bench's own frame expectation built bit by bit.
  task automatic exp_frame(input int code, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input int len, output logic [63:0] v, output int n, output int ntx);
    logic [1:0] op, ex;
    bit ext;
    v = 0; n = 0;
    ext = (code >= 3);
    case (code)
      0: op = 2'b10; 1: op = 2'b01; 2: op = 2'b11; default: op = 2'b00;
    endcase
    case (code)
      4: ex = 2'b01; 5: ex = 2'b10; 6: ex = 2'b11; default: ex = 2'b00;
    endcase
    v = {v[62:0], 1'b1}; n++;
    for (int i = 1; i >= 0; i--) begin v = {v[62:0], op[i]}; n++; end
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      logic b;
      if (ext) b = (i == ADDR_W - 1) ? ex[1] : (i == ADDR_W - 2) ? ex[0] : 1'b0;
      else     b = a[i];
      v = {v[62:0], b}; n++;
    end
    if (code == 1 || code == 4)
      for (int i = len - 1; i >= 0; i--) begin v = {v[62:0], d[i]}; n++; end
    ntx = n;
    if (code == 0)
      for (int i = 0; i <= len; i++) begin v = {v[62:0], 1'b0}; n++; end
  endtask

  task automatic wait_done();
    while (!done && !wd) @(negedge clk);
  endtask

  // One full transaction with all standard checks.
  task automatic run_cmd(input int code, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input int len, input logic [DATA_W-1:0] rv, input int rdy, input string nm);
    logic [63:0] ev; int en, ntx;
    bit polls, got_ok; logic [DATA_W-1:0] got_rd;
    exp_frame(code, a, d, len, ev, en, ntx);
    polls = (code == 1 || code == 2 || code == 4 || code == 5);
    @(posedge clk); #1;
    mon_clr = 1; rd_mode = (code == 0); rd_vec = rv; rd_len = len; rdy_after = rdy; exp_tx = ntx;
    @(posedge clk); #1;
    mon_clr = 0; start = 1; cmd = 3'(code); addr = a; wdata = d; dlen = LEN_W'(len);
    @(posedge clk); #1;
    start = 0;
    chk(busy == 1, {nm, " R10 busy after start"}, busy, 1);
    wait_done();
    got_ok = ok; got_rd = rd_data;
    @(posedge clk); #1;
    chk(obs_n == en, {nm, " R1 R3 R6 clock pulse count"}, obs_n, en);
    chk(obs == ev, {nm, " R1 R2 R3 frame bits"}, obs, ev);
    chk(t_err == 0, {nm, " R4 bit timing violations"}, t_err, 0);
    chk(setup_seen == T_CSS + T_SU, {nm, " R5 cs setup cycles"}, setup_seen, T_CSS + T_SU);
    chk(lo_at_done == T_CSH, {nm, " R5 cs low at done"}, lo_at_done, T_CSH);
    if (code == 0) begin
      logic [DATA_W-1:0] m;
      m = (len >= DATA_W) ? rv : (rv & ((DATA_W'(1) << len) - 1'b1));
      chk(got_rd == m, {nm, " R6 read data"}, got_rd, m);
    end
    if (polls) begin
      int ep;
      chk(gap_lo == T_CSH, {nm, " R7 cs drop before poll"}, gap_lo, T_CSH);
      ep = (rdy < 0) ? POLL_MAX * POLL_GAP : ((rdy + POLL_GAP - 1) / POLL_GAP) * POLL_GAP;
      if (ep > POLL_MAX * POLL_GAP) ep = POLL_MAX * POLL_GAP;
      chk(poll_hi == ep, {nm, " R7 R8 poll window cycles"}, poll_hi, ep);
      chk(got_ok == (rdy >= 0 && rdy <= POLL_MAX * POLL_GAP), {nm, " R7 R8 result flag"},
          got_ok, (rdy >= 0));
    end else begin
      chk(cs_sess == 1, {nm, " R9 no poll session"}, cs_sess, 1);
      chk(got_ok == 1, {nm, " R9 ok set"}, got_ok, 1);
    end
    @(negedge clk);
    chk(done == 0 && busy == 0, {nm, " R10 done single cycle"}, {done, busy}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0 && done == 0, "reset R10 busy/done low", {busy, done}, 0);
    chk(cs == 0 && sclk == 0 && dout == 0, "reset R11 idle pins low", {cs, sclk, dout}, 0);
  endtask

  task automatic t_write();
    run_cmd(1, 7'h2A, 16'hA5C3, 16, 0, 7, "write16");
    run_cmd(1, 7'h01, 16'h03C1, 8, 0, 1, "write8");      // R3 only low 8 bits sent
  endtask

  task automatic t_read();
    run_cmd(0, 7'h15, 0, 16, 16'hBEEF, -1, "read16");
    run_cmd(0, 7'h6B, 0, 5, 16'h0013, -1, "read5");
  endtask

  task automatic t_erase();
    run_cmd(2, 7'h7F, 0, 0, 0, 1, "erase");
  endtask

  task automatic t_ext();
    run_cmd(6, 7'h55, 0, 0, 0, -1, "ewen");              // R2 addr ignored
    run_cmd(3, 7'h7F, 0, 0, 0, -1, "ewds");
    run_cmd(5, 7'h33, 0, 0, 0, 23, "eral");
    run_cmd(4, 7'h0F, 16'h1234, 16, 0, 3, "wral");
  endtask

  task automatic t_timeout();
    run_cmd(1, 7'h40, 16'hFFFF, 16, 0, -1, "write timeout R8");
  endtask

  task automatic t_ignore();
    int seen;
    logic [63:0] ev; int en, ntx;
    exp_frame(6, 0, 0, 0, ev, en, ntx);
    @(posedge clk); #1;
    mon_clr = 1; rd_mode = 0; rdy_after = -1; exp_tx = ntx;
    @(posedge clk); #1;
    mon_clr = 0; start = 1; cmd = 3'd6; addr = 0; dlen = 0;
    @(posedge clk); #1;
    start = 0;
    repeat (20) @(posedge clk);
    #1; start = 1; cmd = 3'd1; dlen = 16; wdata = 16'hFFFF;
    @(posedge clk); #1;
    start = 0;
    wait_done();
    @(posedge clk); #1;
    chk(obs == ev && obs_n == en, "R10 start while busy left frame unchanged", obs, ev);
    seen = 0;
    repeat (8) begin @(negedge clk); if (busy) seen++; end
    chk(seen == 0, "R10 no second transaction", seen, 0);
    @(posedge clk); #1;
    start = 1; cmd = 3'd7;
    @(posedge clk); #1;
    start = 0;
    seen = 0;
    repeat (8) begin @(negedge clk); if (busy || cs || sclk) seen++; end
    chk(seen == 0, "R12 code 7 not accepted", seen, 0);
    chk(cs == 0 && dout == 0, "R11 idle after ignored start", {cs, dout}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_write();
    t_read();
    t_erase();
    t_ext();
    t_timeout();
    t_ignore();
    if (wd) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule